// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block sits behind a reorder buffer and decides, once per clock, how many instructions at the head of the granted thread's buffer retire. The buffer presents a window of the oldest `WIN` entries of that thread, each with a valid bit, a ready bit, an eight-bit flag byte, a sequence number and the address of the following instruction. The controller walks the window from the oldest entry. It removes squashed entries, retires executed entries until `WIDTH` have retired, and stops at the first entry that cannot go.

When the walk stops at an unexecuted entry or a faulting entry, the block may report the entry back instead of retiring it. A serialising entry is sent back as a non-speculative request. An unexecuted load is sent back as an uncached request. A faulting entry raises a trap request. The serialising and faulting cases are allowed only when the entry is the first candidate of the cycle and no store is waiting for writeback.

The block keeps a committed PC and next PC per thread, plus a trap-pending bit per thread. Whenever entries left the buffer, it broadcasts the new free-entry count. Every result is registered: the outputs seen after a clock edge describe the inputs present at that edge.

Top module: `rc_retire_ctrl`

## Requirements
- R1: After reset, all message valids, counts, trap-pending bits, committed PCs, next PCs and the full-width counter read zero.
- R2: Flag byte layout: bit0 executed, bit1 squashed, bit2 fault, bit3 non-speculative, bit4 memory barrier, bit5 write barrier, bit6 store-conditional, bit7 load. Slots are examined oldest first (slot 0). The walk stops at the first slot that is not valid or not ready, once `WIDTH` entries have retired, or at a stalling entry. No slot is examined without a grant. `retire_cnt_o` gives the number retired, and `retire_valid_o` is high when that number is nonzero.
- R3: A squashed ready entry is removed without counting as retired. It still counts in `remove_cnt_o`, and it does not make later entries stop being first candidates.
- R4: An unexecuted entry with any of the non-speculative, barrier or store-conditional bits set stalls. If no entry has retired yet in the cycle and stores are not pending, it also issues `nonspec_valid_o` with its sequence number and `nonspec_uncached_o` low. Otherwise it waits silently.
- R5: An unexecuted load with none of the serialising bits set stalls and issues `nonspec_valid_o` with `nonspec_uncached_o` high and its sequence number, whatever the store state and whatever its position.
- R6: An executed entry with the fault bit set stalls. If it is the first candidate and stores are not pending, it raises `trap_req_o` and sets the thread's trap-pending bit. That bit clears on `trap_done_i`, and a new trap wins over a clear in the same cycle.
- R7: When entries retire, `done_valid_o` is high and `done_seq_o` holds the sequence number of the last one retired. The thread's committed PC takes that entry's next address, and its next PC becomes that address plus `INSN_BYTES`.
- R8: While `all_squash_i` is high, nothing is retired, removed or reported.
- R9: When `remove_cnt_o` is nonzero, `free_valid_o` is high and `free_count_o` equals `rob_free_i` plus the removed count. `free_empty_o` is high exactly when that sum equals `DEPTH`.
- R10: An unexecuted entry with no serialising bit and no load bit stalls and pulses `unknown_err_o`. At most one of trap, non-speculative request and error is reported per cycle.
- R11: `full_width_cycles_o` counts, saturating, the cycles in which exactly `WIDTH` entries retired.
- R12: All report messages carry the granted thread in `msg_tid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| grant_valid_i | input | 1 | A thread is granted this cycle |
| grant_tid_i | input | TIDW | Granted thread |
| all_squash_i | input | 1 | Every thread is squashing |
| stores_pending_i | input | 1 | Stores wait for writeback |
| head_valid_i | input | WIN | Slot holds an entry |
| head_ready_i | input | WIN | Slot entry may be considered |
| head_flags_i | input | WIN*8 | Flag byte per slot |
| head_seq_i | input | WIN*SEQW | Sequence number per slot |
| head_npc_i | input | WIN*AW | Next instruction address per slot |
| rob_free_i | input | FCW | Free entries of granted thread before removal |
| trap_done_i | input | THREADS | Clears the trap-pending bit per thread |
| retire_valid_o | output | 1 | At least one entry retired |
| retire_cnt_o | output | CW | Entries retired |
| remove_cnt_o | output | CW | Entries removed, squashed included |
| msg_tid_o | output | TIDW | Thread of all messages |
| done_valid_o | output | 1 | Done sequence number is valid |
| done_seq_o | output | SEQW | Last retired sequence number |
| nonspec_valid_o | output | 1 | Non-speculative or uncached request |
| nonspec_uncached_o | output | 1 | Request is an uncached load |
| nonspec_seq_o | output | SEQW | Sequence number of the request |
| trap_req_o | output | 1 | Trap request |
| trap_pending_o | output | THREADS | Trap-pending bit per thread |
| unknown_err_o | output | 1 | Unexecuted entry of no known class |
| free_valid_o | output | 1 | Free-entry broadcast valid |
| free_count_o | output | FCW | Free entries after removal |
| free_empty_o | output | 1 | Buffer of the thread is empty |
| commit_pc_o | output | THREADS*AW | Committed PC per thread |
| commit_npc_o | output | THREADS*AW | Next PC per thread |
| full_width_cycles_o | output | CNTW | Cycles using the full width |

## Verification
The two functions that can fall in the same cycle are retiring and reporting. Some executed entries retire, and then the walk reaches a serialising, faulting or load entry. Directed cases place a serialising or faulting entry after one executed entry, and after a squashed one, to decide whether it is still the first candidate. The random traffic mixes all classes behind random valid prefixes and stores-pending levels. The bench judges the retire count, the report kind and the carried sequence number against its own walk of the same window.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef struct packed {
    logic ld;
    logic stcond;
    logic wrbar;
    logic membar;
    logic nonspec;
    logic fault;
    logic squashed;
    logic executed;
  } head_flags_t;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_WAIT,
    KIND_NONSPEC,
    KIND_UNCACHED,
    KIND_TRAP,
    KIND_UNKNOWN
  } stop_kind_e;

  function automatic logic is_serialising(head_flags_t f);
    return f.nonspec | f.membar | f.wrbar | f.stcond;
  endfunction

endpackage

// File: rtl/rc_head_scan.sv
module rc_head_scan
  import rc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int WIN   = 6,
  parameter int SEQW  = 16,
  parameter int AW    = 32,
  localparam int CW   = $clog2(WIN + 1)
) (
  input  logic              enable_i,
  input  logic              stores_pending_i,
  input  logic [WIN-1:0]    valid_i,
  input  logic [WIN-1:0]    ready_i,
  input  logic [WIN*8-1:0]  flags_i,
  input  logic [WIN*SEQW-1:0] seq_i,
  input  logic [WIN*AW-1:0] npc_i,
  output logic [CW-1:0]     com_cnt_o,
  output logic [CW-1:0]     rem_cnt_o,
  output stop_kind_e        kind_o,
  output logic [SEQW-1:0]   ev_seq_o,
  output logic [SEQW-1:0]   last_seq_o,
  output logic [AW-1:0]     last_npc_o
);

  head_flags_t f;
  logic        halted;
  int          ncom;
  int          nrem;

  always_comb begin
    halted     = 1'b0;
    ncom       = 0;
    nrem       = 0;
    kind_o     = KIND_NONE;
    ev_seq_o   = '0;
    last_seq_o = '0;
    last_npc_o = '0;
    f          = '0;
    for (int i = 0; i < WIN; i++) begin
      f = head_flags_t'(flags_i[i*8 +: 8]);
      if (enable_i && !halted) begin
        if (ncom == WIDTH) begin
          halted = 1'b1;
        end else if (!valid_i[i] || !ready_i[i]) begin
          halted = 1'b1;
        end else if (f.squashed) begin
          nrem = nrem + 1;
        end else if (!f.executed) begin
          halted = 1'b1;
          if (is_serialising(f)) begin
            if (ncom == 0 && !stores_pending_i) begin
              kind_o   = KIND_NONSPEC;
              ev_seq_o = seq_i[i*SEQW +: SEQW];
            end else begin
              kind_o = KIND_WAIT;
            end
          end else if (f.ld) begin
            kind_o   = KIND_UNCACHED;
            ev_seq_o = seq_i[i*SEQW +: SEQW];
          end else begin
            kind_o = KIND_UNKNOWN;
          end
        end else if (f.fault) begin
          halted = 1'b1;
          kind_o = (ncom == 0 && !stores_pending_i) ? KIND_TRAP : KIND_WAIT;
        end else begin
          ncom       = ncom + 1;
          nrem       = nrem + 1;
          last_seq_o = seq_i[i*SEQW +: SEQW];
          last_npc_o = npc_i[i*AW +: AW];
        end
      end
    end
    com_cnt_o = CW'(ncom);
    rem_cnt_o = CW'(nrem);
  end

endmodule

// File: rtl/rc_thread_state.sv
module rc_thread_state #(
  parameter int THREADS    = 2,
  parameter int TIDW       = 1,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic [TIDW-1:0]       tid_i,
  input  logic [AW-1:0]         tgt_i,
  input  logic                  trap_set_i,
  input  logic [THREADS-1:0]    trap_done_i,
  output logic [THREADS*AW-1:0] pc_o,
  output logic [THREADS*AW-1:0] npc_o,
  output logic [THREADS-1:0]    trap_pending_o
);

  function automatic logic [AW-1:0] step_pc(logic [AW-1:0] a);
    return a + AW'(INSN_BYTES);
  endfunction

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic hit;
    assign hit = (tid_i == TIDW'(t));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        pc_o[t*AW +: AW]  <= '0;
        npc_o[t*AW +: AW] <= '0;
        trap_pending_o[t] <= 1'b0;
      end else begin
        if (adv_i && hit) begin
          pc_o[t*AW +: AW]  <= tgt_i;
          npc_o[t*AW +: AW] <= step_pc(tgt_i);
        end
        if (trap_set_i && hit) begin
          trap_pending_o[t] <= 1'b1;
        end else if (trap_done_i[t]) begin
          trap_pending_o[t] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rc_sat_counter.sv
module rc_sat_counter #(
  parameter int CNTW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  output logic [CNTW-1:0] count_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (hit_i && (count_o != {CNTW{1'b1}})) begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/rc_retire_ctrl.sv
module rc_retire_ctrl
  import rc_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int WIN        = 6,
  parameter int THREADS    = 2,
  parameter int SEQW       = 16,
  parameter int AW         = 32,
  parameter int DEPTH      = 32,
  parameter int INSN_BYTES = 4,
  parameter int CNTW       = 16,
  localparam int TIDW      = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CW        = $clog2(WIN + 1),
  localparam int FCW       = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  grant_valid_i,
  input  logic [TIDW-1:0]       grant_tid_i,
  input  logic                  all_squash_i,
  input  logic                  stores_pending_i,
  input  logic [WIN-1:0]        head_valid_i,
  input  logic [WIN-1:0]        head_ready_i,
  input  logic [WIN*8-1:0]      head_flags_i,
  input  logic [WIN*SEQW-1:0]   head_seq_i,
  input  logic [WIN*AW-1:0]     head_npc_i,
  input  logic [FCW-1:0]        rob_free_i,
  input  logic [THREADS-1:0]    trap_done_i,
  output logic                  retire_valid_o,
  output logic [CW-1:0]         retire_cnt_o,
  output logic [CW-1:0]         remove_cnt_o,
  output logic [TIDW-1:0]       msg_tid_o,
  output logic                  done_valid_o,
  output logic [SEQW-1:0]       done_seq_o,
  output logic                  nonspec_valid_o,
  output logic                  nonspec_uncached_o,
  output logic [SEQW-1:0]       nonspec_seq_o,
  output logic                  trap_req_o,
  output logic [THREADS-1:0]    trap_pending_o,
  output logic                  unknown_err_o,
  output logic                  free_valid_o,
  output logic [FCW-1:0]        free_count_o,
  output logic                  free_empty_o,
  output logic [THREADS*AW-1:0] commit_pc_o,
  output logic [THREADS*AW-1:0] commit_npc_o,
  output logic [CNTW-1:0]       full_width_cycles_o
);

  // named internal events
  logic            scan_en;
  logic [CW-1:0]   com_cnt;
  logic [CW-1:0]   rem_cnt;
  stop_kind_e      stop_kind;
  logic [SEQW-1:0] ev_seq;
  logic [SEQW-1:0] last_seq;
  logic [AW-1:0]   last_npc;
  logic            ev_commit;
  logic            ev_full;
  logic            ev_trap;
  logic            ev_request;
  logic            ev_unknown;
  logic [FCW-1:0]  free_next;

  assign scan_en    = grant_valid_i && !all_squash_i;
  assign ev_commit  = (com_cnt != '0);
  assign ev_full    = (com_cnt == CW'(WIDTH));
  assign ev_trap    = (stop_kind == KIND_TRAP);
  assign ev_request = (stop_kind == KIND_NONSPEC) || (stop_kind == KIND_UNCACHED);
  assign ev_unknown = (stop_kind == KIND_UNKNOWN);
  assign free_next  = rob_free_i + FCW'(rem_cnt);

  rc_head_scan #(
    .WIDTH (WIDTH),
    .WIN   (WIN),
    .SEQW  (SEQW),
    .AW    (AW)
  ) scan_i (
    .enable_i         (scan_en),
    .stores_pending_i (stores_pending_i),
    .valid_i          (head_valid_i),
    .ready_i          (head_ready_i),
    .flags_i          (head_flags_i),
    .seq_i            (head_seq_i),
    .npc_i            (head_npc_i),
    .com_cnt_o        (com_cnt),
    .rem_cnt_o        (rem_cnt),
    .kind_o           (stop_kind),
    .ev_seq_o         (ev_seq),
    .last_seq_o       (last_seq),
    .last_npc_o       (last_npc)
  );

  rc_thread_state #(
    .THREADS    (THREADS),
    .TIDW       (TIDW),
    .AW         (AW),
    .INSN_BYTES (INSN_BYTES)
  ) thr_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .adv_i          (ev_commit),
    .tid_i          (grant_tid_i),
    .tgt_i          (last_npc),
    .trap_set_i     (ev_trap),
    .trap_done_i    (trap_done_i),
    .pc_o           (commit_pc_o),
    .npc_o          (commit_npc_o),
    .trap_pending_o (trap_pending_o)
  );

  rc_sat_counter #(
    .CNTW (CNTW)
  ) full_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (ev_full),
    .count_o (full_width_cycles_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      retire_valid_o     <= 1'b0;
      retire_cnt_o       <= '0;
      remove_cnt_o       <= '0;
      msg_tid_o          <= '0;
      done_valid_o       <= 1'b0;
      done_seq_o         <= '0;
      nonspec_valid_o    <= 1'b0;
      nonspec_uncached_o <= 1'b0;
      nonspec_seq_o      <= '0;
      trap_req_o         <= 1'b0;
      unknown_err_o      <= 1'b0;
      free_valid_o       <= 1'b0;
      free_count_o       <= '0;
      free_empty_o       <= 1'b0;
    end else begin
      retire_valid_o     <= ev_commit;
      retire_cnt_o       <= com_cnt;
      remove_cnt_o       <= rem_cnt;
      msg_tid_o          <= grant_tid_i;
      done_valid_o       <= ev_commit;
      done_seq_o         <= last_seq;
      nonspec_valid_o    <= ev_request;
      nonspec_uncached_o <= (stop_kind == KIND_UNCACHED);
      nonspec_seq_o      <= ev_seq;
      trap_req_o         <= ev_trap;
      unknown_err_o      <= ev_unknown;
      free_valid_o       <= (rem_cnt != '0);
      free_count_o       <= free_next;
      free_empty_o       <= (rem_cnt != '0) && (free_next == FCW'(DEPTH));
    end
  end

endmodule

// File: rtl/rc_retire_checker.sv
module rc_retire_checker #(
  parameter int WIDTH   = 4,
  parameter int THREADS = 2,
  parameter int TIDW    = 1,
  parameter int CW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               all_squash_i,
  input logic               stores_pending_i,
  input logic               retire_valid_o,
  input logic [CW-1:0]      retire_cnt_o,
  input logic [CW-1:0]      remove_cnt_o,
  input logic [TIDW-1:0]    msg_tid_o,
  input logic               done_valid_o,
  input logic               nonspec_valid_o,
  input logic               nonspec_uncached_o,
  input logic               trap_req_o,
  input logic [THREADS-1:0] trap_pending_o,
  input logic               unknown_err_o,
  input logic               free_valid_o
);

  assert_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_cnt_o <= CW'(WIDTH));

  assert_retire_le_remove_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_cnt_o <= remove_cnt_o);

  assert_serial_drained_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nonspec_valid_o && !nonspec_uncached_o) |-> (retire_cnt_o == '0 && $past(!stores_pending_i)));

  assert_trap_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (retire_cnt_o == '0 && $past(!stores_pending_i)));

  assert_trap_marks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> trap_pending_o[msg_tid_o]);

  assert_done_with_retire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> done_valid_o);

  assert_squash_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(all_squash_i) |-> (remove_cnt_o == '0 && !trap_req_o && !nonspec_valid_o && !unknown_err_o));

  assert_free_bcast_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remove_cnt_o != '0) |-> free_valid_o);

  assert_one_report_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_req_o, nonspec_valid_o, unknown_err_o}));

endmodule

bind rc_retire_ctrl rc_retire_checker #(
  .WIDTH   (WIDTH),
  .THREADS (THREADS),
  .TIDW    (TIDW),
  .CW      (CW)
) chk_i (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .all_squash_i       (all_squash_i),
  .stores_pending_i   (stores_pending_i),
  .retire_valid_o     (retire_valid_o),
  .retire_cnt_o       (retire_cnt_o),
  .remove_cnt_o       (remove_cnt_o),
  .msg_tid_o          (msg_tid_o),
  .done_valid_o       (done_valid_o),
  .nonspec_valid_o    (nonspec_valid_o),
  .nonspec_uncached_o (nonspec_uncached_o),
  .trap_req_o         (trap_req_o),
  .trap_pending_o     (trap_pending_o),
  .unknown_err_o      (unknown_err_o),
  .free_valid_o       (free_valid_o)
);

// File: tb/rc_retire_ctrl_tb_top.sv
module rc_retire_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 4;
  localparam int WIN = 6;
  localparam int THREADS = 2;
  localparam int SEQW = 16;
  localparam int AW = 32;
  localparam int DEPTH = 32;
  localparam int INSN_BYTES = 4;
  localparam int CNTW = 16;
  localparam int TIDW = 1;
  localparam int CW = $clog2(WIN + 1);
  localparam int FCW = $clog2(DEPTH + 1);

  localparam logic [7:0] FX  = 8'h01;
  localparam logic [7:0] FSQ = 8'h02;
  localparam logic [7:0] FFT = 8'h04;
  localparam logic [7:0] FNS = 8'h08;
  localparam logic [7:0] FMB = 8'h10;
  localparam logic [7:0] FWB = 8'h20;
  localparam logic [7:0] FSC = 8'h40;
  localparam logic [7:0] FLD = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic gv, asq, stp;
  logic [TIDW-1:0] gtid;
  logic [WIN-1:0] hv, hr;
  logic [7:0] fl [WIN];
  logic [SEQW-1:0] sq [WIN];
  logic [AW-1:0] np [WIN];
  logic [FCW-1:0] rfree;
  logic [THREADS-1:0] tdone;

  logic [WIN*8-1:0] flags_bus;
  logic [WIN*SEQW-1:0] seq_bus;
  logic [WIN*AW-1:0] npc_bus;
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      flags_bus[k*8 +: 8] = fl[k];
      seq_bus[k*SEQW +: SEQW] = sq[k];
      npc_bus[k*AW +: AW] = np[k];
    end
  end

  logic retire_valid, done_valid, ns_valid, ns_unc, trap_req, uerr, fvalid, fempty;
  logic [CW-1:0] rcnt, rmcnt;
  logic [TIDW-1:0] mtid;
  logic [SEQW-1:0] dseq, nsseq;
  logic [THREADS-1:0] tpend;
  logic [FCW-1:0] fcount;
  logic [THREADS*AW-1:0] cpc, cnpc;
  logic [CNTW-1:0] fullcnt;

  rc_retire_ctrl #(
    .WIDTH(WIDTH), .WIN(WIN), .THREADS(THREADS), .SEQW(SEQW), .AW(AW),
    .DEPTH(DEPTH), .INSN_BYTES(INSN_BYTES), .CNTW(CNTW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grant_valid_i(gv), .grant_tid_i(gtid),
    .all_squash_i(asq), .stores_pending_i(stp), .head_valid_i(hv),
    .head_ready_i(hr), .head_flags_i(flags_bus), .head_seq_i(seq_bus),
    .head_npc_i(npc_bus), .rob_free_i(rfree), .trap_done_i(tdone),
    .retire_valid_o(retire_valid), .retire_cnt_o(rcnt), .remove_cnt_o(rmcnt),
    .msg_tid_o(mtid), .done_valid_o(done_valid), .done_seq_o(dseq),
    .nonspec_valid_o(ns_valid), .nonspec_uncached_o(ns_unc),
    .nonspec_seq_o(nsseq), .trap_req_o(trap_req), .trap_pending_o(tpend),
    .unknown_err_o(uerr), .free_valid_o(fvalid), .free_count_o(fcount),
    .free_empty_o(fempty), .commit_pc_o(cpc), .commit_npc_o(cnpc),
    .full_width_cycles_o(fullcnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side state and expectations
  logic [AW-1:0] m_pc [THREADS];
  logic [AW-1:0] m_npc [THREADS];
  logic [THREADS-1:0] m_tp;
  int m_full;
  int e_ret, e_rem;
  bit e_ns, e_unc, e_trap, e_err;
  logic [SEQW-1:0] e_nsseq, e_dseq;

  function automatic bit serial_class(logic [7:0] f);
    return (f & (FNS | FMB | FWB | FSC)) != 0;
  endfunction

  task automatic predict();
    int done_n = 0;
    int gone = 0;
    bit stop = 0;
    logic [AW-1:0] tgt = '0;
    e_ns = 0; e_unc = 0; e_trap = 0; e_err = 0; e_nsseq = '0; e_dseq = '0;
    if (gv && !asq) begin
      for (int k = 0; k < WIN; k++) begin
        if (stop) continue;
        if (done_n == WIDTH || !hv[k] || !hr[k]) begin
          stop = 1;
        end else if (fl[k][1]) begin
          gone++;
        end else if (!fl[k][0]) begin
          stop = 1;
          if (serial_class(fl[k])) begin
            if (done_n == 0 && !stp) begin e_ns = 1; e_nsseq = sq[k]; end
          end else if (fl[k][7]) begin
            e_ns = 1; e_unc = 1; e_nsseq = sq[k];
          end else begin
            e_err = 1;
          end
        end else if (fl[k][2]) begin
          stop = 1;
          e_trap = (done_n == 0 && !stp);
        end else begin
          done_n++; gone++; e_dseq = sq[k]; tgt = np[k];
        end
      end
    end
    e_ret = done_n;
    e_rem = gone;
    if (done_n > 0) begin
      m_pc[gtid] = tgt;
      m_npc[gtid] = tgt + INSN_BYTES;
    end
    for (int t = 0; t < THREADS; t++) begin
      if (e_trap && gtid == t) m_tp[t] = 1'b1;
      else if (tdone[t]) m_tp[t] = 1'b0;
    end
    if (done_n == WIDTH) m_full++;
  endtask

  task automatic step(input string lbl);
    predict();
    @(posedge clk);
    #1;
    chk({lbl, " R2 retire count"}, 64'(rcnt), 64'(e_ret));
    chk({lbl, " R2 retire valid"}, 64'(retire_valid), 64'(e_ret > 0));
    chk({lbl, " R3 remove count"}, 64'(rmcnt), 64'(e_rem));
    chk({lbl, " R7 done valid"}, 64'(done_valid), 64'(e_ret > 0));
    if (e_ret > 0) chk({lbl, " R7 done seq"}, 64'(dseq), 64'(e_dseq));
    chk({lbl, " R4 R5 request"}, 64'({ns_valid, ns_valid & ns_unc}), 64'({e_ns, e_unc}));
    if (e_ns) chk({lbl, " R4 R5 request seq"}, 64'(nsseq), 64'(e_nsseq));
    chk({lbl, " R6 trap"}, 64'(trap_req), 64'(e_trap));
    chk({lbl, " R6 trap pending"}, 64'(tpend), 64'(m_tp));
    chk({lbl, " R10 unknown"}, 64'(uerr), 64'(e_err));
    if (e_ns || e_trap || e_err || e_ret > 0) chk({lbl, " R12 tid"}, 64'(mtid), 64'(gtid));
    chk({lbl, " R9 free valid"}, 64'(fvalid), 64'(e_rem > 0));
    if (e_rem > 0) begin
      chk({lbl, " R9 free count"}, 64'(fcount), 64'(int'(rfree) + e_rem));
      chk({lbl, " R9 empty"}, 64'(fempty), 64'((int'(rfree) + e_rem) == DEPTH));
    end
    for (int t = 0; t < THREADS; t++) begin
      chk({lbl, " R7 pc"}, 64'(cpc[t*AW +: AW]), 64'(m_pc[t]));
      chk({lbl, " R7 npc"}, 64'(cnpc[t*AW +: AW]), 64'(m_npc[t]));
    end
    chk({lbl, " R11 full count"}, 64'(fullcnt), 64'(m_full));
  endtask

  task automatic clear_stim();
    gv = 1'b1; gtid = '0; asq = 1'b0; stp = 1'b0; hv = '0; hr = '1;
    tdone = '0; rfree = FCW'(DEPTH - WIN);
    for (int k = 0; k < WIN; k++) begin
      fl[k] = FX; sq[k] = SEQW'(16'h100 + k); np[k] = AW'(32'h1000 + 4*k);
    end
  endtask

  task automatic rand_stim();
    int len, extra, p;
    gv = ($urandom % 8) != 0;
    gtid = TIDW'($urandom % THREADS);
    asq = ($urandom % 12) == 0;
    stp = ($urandom % 3) == 0;
    len = $urandom % (WIN + 1);
    extra = $urandom % 3;
    rfree = FCW'(DEPTH - len - extra);
    for (int t = 0; t < THREADS; t++) tdone[t] = ($urandom % 8) == 0;
    for (int k = 0; k < WIN; k++) begin
      hv[k] = (k < len);
      hr[k] = ($urandom % 10) != 0;
      sq[k] = SEQW'($urandom);
      np[k] = AW'($urandom) & ~AW'(3);
      p = $urandom % 20;
      if (p < 13) fl[k] = FX;
      else if (p < 15) fl[k] = FSQ | (($urandom % 2) ? FX : 8'h00);
      else if (p == 15) fl[k] = FX | FFT;
      else if (p == 16) fl[k] = FNS;
      else if (p == 17) fl[k] = (($urandom % 3) == 0) ? FMB : ((($urandom % 2) == 0) ? FWB : FSC);
      else if (p == 18) fl[k] = FLD;
      else fl[k] = 8'h00;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < THREADS; t++) begin m_pc[t] = '0; m_npc[t] = '0; end
    m_tp = '0; m_full = 0;
    clear_stim();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 retire valid", 64'(retire_valid), 64'd0);
    chk("R1 counts", 64'({rcnt, rmcnt}), 64'd0);
    chk("R1 messages", 64'({ns_valid, trap_req, uerr, fvalid, done_valid}), 64'd0);
    chk("R1 trap pending", 64'(tpend), 64'd0);
    chk("R1 pcs", 64'(cpc | cnpc), 64'd0);
    chk("R1 full counter", 64'(fullcnt), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R11 width limit with six executed entries
    @(negedge clk); clear_stim(); hv = '1; step("D width");
    // R2 stop at not-ready slot
    @(negedge clk); clear_stim(); hv = '1; hr[2] = 1'b0; step("D not ready");
    // R2 no grant
    @(negedge clk); clear_stim(); hv = '1; gv = 1'b0; step("D no grant");
    // R3 squashed entries do not count
    @(negedge clk); clear_stim(); hv = '1; fl[0] = FSQ; fl[1] = FSQ; step("D squashed");
    // R4 serialising after a retire waits
    @(negedge clk); clear_stim(); hv = '1; fl[1] = FNS; step("D serial second");
    // R4 serialising first but stores pending
    @(negedge clk); clear_stim(); hv = '1; fl[0] = FMB; stp = 1'b1; step("D serial stores");
    // R4 serialising first and drained
    @(negedge clk); clear_stim(); hv = '1; fl[0] = FWB; step("D serial go");
    // R3 R4 squashed ahead keeps it first
    @(negedge clk); clear_stim(); hv = '1; fl[0] = FSQ; fl[1] = FSC; step("D squash then serial");
    // R5 uncached load despite stores and position
    @(negedge clk); clear_stim(); hv = '1; fl[2] = FLD; stp = 1'b1; step("D uncached");
    // R6 fault after a retire waits
    @(negedge clk); clear_stim(); hv = '1; fl[1] = FX | FFT; step("D fault second");
    // R6 fault first raises trap on thread 1
    @(negedge clk); clear_stim(); hv = '1; gtid = 1'b1; fl[0] = FX | FFT; step("D trap");
    // R6 trap pending clears
    @(negedge clk); clear_stim(); tdone = 2'b10; step("D trap done");
    // R8 all threads squashing
    @(negedge clk); clear_stim(); hv = '1; asq = 1'b1; step("D all squash");
    // R10 unknown unexecuted class
    @(negedge clk); clear_stim(); hv = '1; fl[0] = 8'h00; step("D unknown");
    // R9 exact occupancy empties the buffer
    @(negedge clk); clear_stim(); hv = 6'b000111; rfree = FCW'(DEPTH - 3); step("D empty");

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      rand_stim();
      step("rand");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule